// File: doc/BRIEF.md
# Register-List DMA Engine

This engine walks a table of register updates held in memory and replays it as writes on a target register write port, so a burst of configuration changes can land at a precise moment, such as a frame boundary, without a processor touching each register. Software places the table in memory, programs an inclusive byte window for a channel, and then either launches the manual channel or arms one of the auto channels. An armed auto channel runs its table whenever its selected trigger input pulses.

The table is read one 32-bit word at a time through a simple request/valid memory port with one request outstanding at any moment. In pair mode, every 8-byte entry holds a target address followed by a data value. In stream mode, the first word is a base address and every following word is written to consecutive addresses from that base. Only one channel fetches at a time. Channel requests wait in a pending set and are served manual first, then the lowest-numbered auto channel. Each channel has a done flag, cleared by writing one, and an error flag for a malformed window. The interrupt stays high while any done flag is set.

Top module: `reglist_dma`

## Requirements
- R1: In pair mode (mode bit 0), memory words are fetched from the window start upward in steps of 4 bytes. The word at the lower address of each 8-byte entry is the target address and the next word is the data, and one register write per entry is issued in table order.
- R2: The end register holds the inclusive last byte. A window of N entries (end = start + 8N - 1) gives exactly N writes and 2N word reads, after which the channel's done flag is set.
- R3: In stream mode (mode bit 1), the first word is a base address and each later word in the window is written to base, base+1, base+2 and so on.
- R4: The manual channel access register (word 2) has bit 0 = start, bit 1 = mode and bit 2 = write direction. A transfer launches only when a write sets bit 0 while its stored value is 0. Writing 1 again while the bit is already 1 launches nothing.
- R5: Auto channel k (1..7) has a source register at word 23+k, with bit 5 = armed and the low bits = trigger index. The channel runs on a pulse of the selected trigger input only while armed, and other inputs or disarmed pulses have no effect. For k = 1..3, the mode bit is bit k and the write bit is bit k+4 of word 3. For k = 4..7, they are bits k-4 and k of word 4. The window start and end of channel c are at words 8+2c and 9+2c.
- R6: Requests pending together are served manual first, then the lowest-numbered auto channel. A trigger that arrives while another table runs is held and served after it.
- R7: At most one memory read is outstanding. A new request is not issued until the previous word has returned.
- R8: Status word 1 shows channel c's done flag in bit 24+c. Writing 1 to bit 24+c of control word 0 clears it, and writing 0 leaves it unchanged.
- R9: The irq output is high while any done flag is set and low once all are cleared.
- R10: If end < start, or the window length is not a multiple of 8 bytes, the channel sets error bit 16+c of the status word (cleared by writing 1 to control bit 16+c). It then makes no memory reads and no register writes, and its done flag stays clear.
- R11: With the write direction bit at 0, a launched channel reads nothing, writes nothing and sets its done flag at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Control register write strobe |
| csr_addr | input | 6 | Control register word index |
| csr_wdata | input | 32 | Control register write data |
| csr_rdata | output | 32 | Control register read data (combinational) |
| trig_in | input | TRIG_N | Trigger pulses for the auto channels |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rdata | input | 32 | Returned memory word |
| mem_rvalid | input | 1 | Returned word valid |
| rw_en | output | 1 | Target register write strobe |
| rw_addr | output | AW | Target register address |
| rw_data | output | 32 | Target register write data |
| done_flags | output | NAUTO+1 | Per-channel done flags, manual in bit 0 |
| irq | output | 1 | Interrupt, OR of the done flags |

## Verification
The engine is driven with a three-entry pair-mode table, a stream-mode table whose writes land at incrementing addresses, and windows that are too short or reversed. Comparing write streams and read counts across these tables separates entry parsing, end-of-window detection and the length check. Auto channels get pulses on the wrong input, pulses while disarmed and pulses while armed, which shows that only the selected, armed source starts a run. A manual launch and a shared trigger for two auto channels in the same cycle show, through the order of the written values, both the priority rule and that held requests survive a busy engine.

// File: rtl/rld_pkg.sv
package rld_pkg;
   localparam logic [5:0] A_CTRL    = 6'd0;
   localparam logic [5:0] A_STAT    = 6'd1;
   localparam logic [5:0] A_MAN     = 6'd2;
   localparam logic [5:0] A_AUTO_LO = 6'd3;
   localparam logic [5:0] A_AUTO_HI = 6'd4;
   localparam int unsigned A_WIN    = 8;
   localparam int unsigned A_SRC    = 24;
   localparam int unsigned DONE_LSB = 24;
   localparam int unsigned ERR_LSB  = 16;
   localparam int unsigned ARM_BIT  = 5;

   typedef enum logic [1:0] {
      F_IDLE,
      F_REQ,
      F_WAIT
   } fetch_st_e;
endpackage

// File: rtl/rld_csr.sv
module rld_csr
   import rld_pkg::*;
#(
   parameter int unsigned NAUTO  = 7,
   parameter int unsigned AW     = 32,
   parameter int unsigned TRIG_N = 4,
   localparam int unsigned NCH    = NAUTO + 1,
   localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned TSEL_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              csr_we,
   input  logic [5:0]                        csr_addr,
   input  logic [31:0]                       csr_wdata,
   output logic [31:0]                       csr_rdata,
   input  logic                              busy,
   input  logic                              evt_done,
   input  logic                              evt_err,
   input  logic [CH_W-1:0]                   evt_ch,
   output logic [NCH-1:0][AW-1:0]            cfg_start,
   output logic [NCH-1:0][AW-1:0]            cfg_end,
   output logic [NCH-1:0]                    cfg_inc,
   output logic [NCH-1:0]                    cfg_wr,
   output logic                              man_launch,
   output logic [NAUTO-1:0]                  arm,
   output logic [NAUTO-1:0][TSEL_W-1:0]      tsel,
   output logic [NCH-1:0]                    done_o,
   output logic                              irq
);
   logic [2:0]     man_q;
   logic [7:0]     lo_q;
   logic [7:0]     hi_q;
   logic [NCH-1:0] done_q;
   logic [NCH-1:0] err_q;
   logic           clr_w;

   assign clr_w      = csr_we && (csr_addr == A_CTRL);
   assign man_launch = csr_we && (csr_addr == A_MAN) && csr_wdata[0] && !man_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         man_q <= '0;
         lo_q  <= '0;
         hi_q  <= '0;
      end else if (csr_we) begin
         case (csr_addr)
            A_MAN:     man_q <= csr_wdata[2:0];
            A_AUTO_LO: lo_q  <= csr_wdata[7:0];
            A_AUTO_HI: hi_q  <= csr_wdata[7:0];
            default:   ;
         endcase
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_win
      logic [AW-1:0] s_q;
      logic [AW-1:0] e_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_q <= '0;
            e_q <= '0;
         end else if (csr_we) begin
            if (csr_addr == 6'(A_WIN + 2 * c))     s_q <= csr_wdata[AW-1:0];
            if (csr_addr == 6'(A_WIN + 2 * c + 1)) e_q <= csr_wdata[AW-1:0];
         end
      end
      assign cfg_start[c] = s_q;
      assign cfg_end[c]   = e_q;
      if (c == 0) begin : g_man
         assign cfg_inc[c] = man_q[1];
         assign cfg_wr[c]  = man_q[2];
      end else if (c <= 3) begin : g_lo
         assign cfg_inc[c] = lo_q[c];
         assign cfg_wr[c]  = lo_q[c+4];
      end else begin : g_hi
         assign cfg_inc[c] = hi_q[c-4];
         assign cfg_wr[c]  = hi_q[c];
      end
   end

   for (genvar k = 0; k < NAUTO; k++) begin : g_src
      logic              arm_q;
      logic [TSEL_W-1:0] sel_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            arm_q <= 1'b0;
            sel_q <= '0;
         end else if (csr_we && csr_addr == 6'(A_SRC + k)) begin
            arm_q <= csr_wdata[ARM_BIT];
            sel_q <= csr_wdata[TSEL_W-1:0];
         end
      end
      assign arm[k]  = arm_q;
      assign tsel[k] = sel_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= '0;
         err_q  <= '0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (evt_done && evt_ch == CH_W'(c))
               done_q[c] <= 1'b1;
            else if (clr_w && csr_wdata[DONE_LSB+c])
               done_q[c] <= 1'b0;
            if (evt_err && evt_ch == CH_W'(c))
               err_q[c] <= 1'b1;
            else if (clr_w && csr_wdata[ERR_LSB+c])
               err_q[c] <= 1'b0;
         end
      end
   end

   assign done_o = done_q;
   assign irq    = |done_q;

   always_comb begin
      csr_rdata = '0;
      case (csr_addr)
         A_STAT: begin
            csr_rdata[DONE_LSB +: NCH] = done_q;
            csr_rdata[ERR_LSB +: NCH]  = err_q;
            csr_rdata[0]               = busy;
         end
         A_MAN:     csr_rdata[2:0] = man_q;
         A_AUTO_LO: csr_rdata[7:0] = lo_q;
         A_AUTO_HI: csr_rdata[7:0] = hi_q;
         default:   ;
      endcase
      for (int c = 0; c < NCH; c++) begin
         if (csr_addr == 6'(A_WIN + 2 * c))     csr_rdata[AW-1:0] = cfg_start[c];
         if (csr_addr == 6'(A_WIN + 2 * c + 1)) csr_rdata[AW-1:0] = cfg_end[c];
      end
      for (int k = 0; k < NAUTO; k++) begin
         if (csr_addr == 6'(A_SRC + k)) begin
            csr_rdata[TSEL_W-1:0] = tsel[k];
            csr_rdata[ARM_BIT]    = arm[k];
         end
      end
   end

   assert_irq_on_done_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |=> irq);

   assert_w1c_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && csr_wdata[DONE_LSB] && !(evt_done && evt_ch == '0)) |=> !done_o[0]);

   assert_flag_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o[0] && !clr_w) |=> done_o[0]);
endmodule

// File: rtl/rld_arb.sv
module rld_arb #(
   parameter int unsigned NAUTO  = 7,
   parameter int unsigned TRIG_N = 4,
   localparam int unsigned NCH    = NAUTO + 1,
   localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned TSEL_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1,
   localparam int unsigned TEXT   = 1 << TSEL_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         man_launch,
   input  logic [TRIG_N-1:0]            trig,
   input  logic [NAUTO-1:0]             arm,
   input  logic [NAUTO-1:0][TSEL_W-1:0] tsel,
   input  logic                         take,
   input  logic [CH_W-1:0]              take_ch,
   output logic                         gnt_valid,
   output logic [CH_W-1:0]              gnt_ch
);
   logic [NCH-1:0]  pend_q;
   logic [NCH-1:0]  hit;
   logic [TEXT-1:0] trig_x;

   assign trig_x = TEXT'(trig);
   assign hit[0] = man_launch;

   for (genvar k = 0; k < NAUTO; k++) begin : g_hit
      assign hit[k+1] = arm[k] && trig_x[tsel[k]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (hit[c])
               pend_q[c] <= 1'b1;
            else if (take && take_ch == CH_W'(c))
               pend_q[c] <= 1'b0;
         end
      end
   end

   always_comb begin
      gnt_valid = |pend_q;
      gnt_ch    = '0;
      for (int c = NCH - 1; c >= 0; c--) begin
         if (pend_q[c]) gnt_ch = CH_W'(c);
      end
   end

   assert_man_first_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[0] |-> (gnt_valid && gnt_ch == '0));

   assert_grant_pending_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> pend_q[gnt_ch]);

   for (genvar c = 0; c < NCH; c++) begin : g_hold
      assert_pend_held_R6 : assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[c] && !(take && take_ch == CH_W'(c))) |=> pend_q[c]);
   end
endmodule

// File: rtl/rld_fetch.sv
module rld_fetch
   import rld_pkg::*;
#(
   parameter int unsigned NAUTO = 7,
   parameter int unsigned AW    = 32,
   localparam int unsigned NCH   = NAUTO + 1,
   localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   gnt_valid,
   input  logic [CH_W-1:0]        gnt_ch,
   input  logic [NCH-1:0][AW-1:0] cfg_start,
   input  logic [NCH-1:0][AW-1:0] cfg_end,
   input  logic [NCH-1:0]         cfg_inc,
   input  logic [NCH-1:0]         cfg_wr,
   output logic                   take,
   output logic                   busy,
   output logic                   evt_done,
   output logic                   evt_err,
   output logic [CH_W-1:0]        evt_ch,
   output logic                   mem_req,
   output logic [AW-1:0]          mem_addr,
   input  logic [31:0]            mem_rdata,
   input  logic                   mem_rvalid,
   output logic                   rw_en,
   output logic [AW-1:0]          rw_addr,
   output logic [31:0]            rw_data
);
   fetch_st_e       st_q;
   logic [CH_W-1:0] ch_q;
   logic [AW-1:0]   ptr_q;
   logic [AW-1:0]   last_q;
   logic [AW-1:0]   tgt_q;
   logic            inc_q;
   logic            aphase_q;
   logic [AW-1:0]   sel_start;
   logic [AW-1:0]   sel_end;
   logic [AW-1:0]   span;
   logic            bad;

   assign sel_start = cfg_start[gnt_ch];
   assign sel_end   = cfg_end[gnt_ch];
   assign span      = sel_end - sel_start + AW'(1);
   assign bad       = (sel_end < sel_start) || (span[2:0] != 3'd0);
   assign take      = (st_q == F_IDLE) && gnt_valid;
   assign busy      = (st_q != F_IDLE);
   assign mem_req   = (st_q == F_REQ);
   assign mem_addr  = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= F_IDLE;
         ch_q     <= '0;
         ptr_q    <= '0;
         last_q   <= '0;
         tgt_q    <= '0;
         inc_q    <= 1'b0;
         aphase_q <= 1'b1;
         evt_done <= 1'b0;
         evt_err  <= 1'b0;
         evt_ch   <= '0;
         rw_en    <= 1'b0;
         rw_addr  <= '0;
         rw_data  <= '0;
      end else begin
         evt_done <= 1'b0;
         evt_err  <= 1'b0;
         rw_en    <= 1'b0;
         case (st_q)
            F_IDLE: begin
               if (gnt_valid) begin
                  ch_q   <= gnt_ch;
                  evt_ch <= gnt_ch;
                  if (bad) begin
                     evt_err <= 1'b1;
                  end else if (!cfg_wr[gnt_ch]) begin
                     evt_done <= 1'b1;
                  end else begin
                     ptr_q    <= sel_start;
                     last_q   <= sel_end;
                     inc_q    <= cfg_inc[gnt_ch];
                     aphase_q <= 1'b1;
                     st_q     <= F_REQ;
                  end
               end
            end
            F_REQ: st_q <= F_WAIT;
            F_WAIT: begin
               if (mem_rvalid) begin
                  if (aphase_q) begin
                     tgt_q    <= mem_rdata[AW-1:0];
                     aphase_q <= 1'b0;
                  end else begin
                     rw_en    <= 1'b1;
                     rw_addr  <= tgt_q;
                     rw_data  <= mem_rdata;
                     aphase_q <= !inc_q;
                     if (inc_q) tgt_q <= tgt_q + AW'(1);
                  end
                  if (ptr_q + AW'(3) == last_q) begin
                     evt_done <= 1'b1;
                     evt_ch   <= ch_q;
                     st_q     <= F_IDLE;
                  end else begin
                     ptr_q <= ptr_q + AW'(4);
                     st_q  <= F_REQ;
                  end
               end
            end
            default: st_q <= F_IDLE;
         endcase
      end
   end

   assert_one_outstanding_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   assert_write_after_data_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      rw_en |-> $past(mem_rvalid));

   assert_err_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      evt_err |-> (!evt_done && !rw_en));
endmodule

// File: rtl/reglist_dma.sv
module reglist_dma #(
   parameter int unsigned NAUTO  = 7,
   parameter int unsigned AW     = 32,
   parameter int unsigned TRIG_N = 4,
   localparam int unsigned NCH    = NAUTO + 1,
   localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned TSEL_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [5:0]        csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic [TRIG_N-1:0] trig_in,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_rvalid,
   output logic              rw_en,
   output logic [AW-1:0]     rw_addr,
   output logic [31:0]       rw_data,
   output logic [NCH-1:0]    done_flags,
   output logic              irq
);
   if (NAUTO < 1 || NAUTO > 7) begin : g_chk_nauto
      $error("reglist_dma: NAUTO must lie in 1..7");
   end
   if (AW < 8 || AW > 32) begin : g_chk_aw
      $error("reglist_dma: AW must lie in 8..32");
   end
   if (TRIG_N < 1 || TRIG_N > 32) begin : g_chk_trig
      $error("reglist_dma: TRIG_N must lie in 1..32");
   end

   logic [NCH-1:0][AW-1:0]       cfg_start;
   logic [NCH-1:0][AW-1:0]       cfg_end;
   logic [NCH-1:0]               cfg_inc;
   logic [NCH-1:0]               cfg_wr;
   logic                         man_launch;
   logic [NAUTO-1:0]             arm;
   logic [NAUTO-1:0][TSEL_W-1:0] tsel;
   logic                         gnt_valid;
   logic [CH_W-1:0]              gnt_ch;
   logic                         take;
   logic                         busy;
   logic                         evt_done;
   logic                         evt_err;
   logic [CH_W-1:0]              evt_ch;

   rld_csr #(.NAUTO(NAUTO), .AW(AW), .TRIG_N(TRIG_N)) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .csr_we     (csr_we),
      .csr_addr   (csr_addr),
      .csr_wdata  (csr_wdata),
      .csr_rdata  (csr_rdata),
      .busy       (busy),
      .evt_done   (evt_done),
      .evt_err    (evt_err),
      .evt_ch     (evt_ch),
      .cfg_start  (cfg_start),
      .cfg_end    (cfg_end),
      .cfg_inc    (cfg_inc),
      .cfg_wr     (cfg_wr),
      .man_launch (man_launch),
      .arm        (arm),
      .tsel       (tsel),
      .done_o     (done_flags),
      .irq        (irq)
   );

   rld_arb #(.NAUTO(NAUTO), .TRIG_N(TRIG_N)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .man_launch (man_launch),
      .trig       (trig_in),
      .arm        (arm),
      .tsel       (tsel),
      .take       (take),
      .take_ch    (gnt_ch),
      .gnt_valid  (gnt_valid),
      .gnt_ch     (gnt_ch)
   );

   rld_fetch #(.NAUTO(NAUTO), .AW(AW)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .gnt_valid  (gnt_valid),
      .gnt_ch     (gnt_ch),
      .cfg_start  (cfg_start),
      .cfg_end    (cfg_end),
      .cfg_inc    (cfg_inc),
      .cfg_wr     (cfg_wr),
      .take       (take),
      .busy       (busy),
      .evt_done   (evt_done),
      .evt_err    (evt_err),
      .evt_ch     (evt_ch),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rdata  (mem_rdata),
      .mem_rvalid (mem_rvalid),
      .rw_en      (rw_en),
      .rw_addr    (rw_addr),
      .rw_data    (rw_data)
   );
endmodule

// File: tb/reglist_dma_bench.sv
module reglist_dma_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [5:0]  csr_addr = 6'd1;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic [3:0]  trig_in = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_rdata = '0;
   logic        mem_rvalid = 1'b0;
   logic        rw_en;
   logic [31:0] rw_addr;
   logic [31:0] rw_data;
   logic [7:0]  done_flags;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   bit ended  = 0;
   logic [63:0] exp_q[$];
   logic [31:0] mem_words [0:255];
   logic        rv_d1 = 1'b0;
   logic [31:0] a_d1 = '0;

   always #5 clk = ~clk;

   reglist_dma u_reglist_dma (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trig_in(trig_in),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_rvalid(mem_rvalid), .rw_en(rw_en), .rw_addr(rw_addr),
      .rw_data(rw_data), .done_flags(done_flags), .irq(irq)
   );

   // memory model: two-cycle read latency
   always @(posedge clk) begin
      rv_d1      <= mem_req;
      a_d1       <= mem_addr;
      mem_rvalid <= rv_d1;
      mem_rdata  <= mem_words[a_d1[9:2]];
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (mem_req) rd_cnt++;
      if (rw_en) begin
         wr_cnt++;
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R1: unexpected write actual %h:%h expected none", rw_addr, rw_data);
         end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            if ({rw_addr, rw_data} !== e) begin
               fails++;
               $display("FAIL R1/R3/R6: write actual %h:%h expected %h:%h",
                        rw_addr, rw_data, e[63:32], e[31:0]);
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0; csr_addr = 6'd1;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_addr = a;
      #1 d = csr_rdata;
      csr_addr = 6'd1;
   endtask

   task automatic wait_bits(input logic [31:0] m);
      logic [31:0] s;
      for (int i = 0; i < 2000; i++) begin
         rd(6'd1, s);
         if ((s & m) == m) return;
      end
   endtask

   task automatic pulse(input logic [3:0] t);
      @(negedge clk); trig_in = t;
      @(negedge clk); trig_in = '0;
   endtask

   task automatic exp_w(input logic [31:0] a, input logic [31:0] d);
      exp_q.push_back({a, d});
   endtask

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      if (!ended) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] s;
      int r0, w0;
      for (int i = 0; i < 256; i++) mem_words[i] = '0;
      mem_words[8'h40] = 32'h60; mem_words[8'h41] = 32'hFFFF_FFFF;
      mem_words[8'h42] = 32'h61; mem_words[8'h43] = 32'hFFFF_FFFE;
      mem_words[8'h44] = 32'h62; mem_words[8'h45] = 32'h1234_5678;
      mem_words[8'h80] = 32'h3210; mem_words[8'h81] = 32'hAAAA_0001;
      mem_words[8'h82] = 32'hAAAA_0002; mem_words[8'h83] = 32'hAAAA_0003;
      mem_words[8'hC0] = 32'h70; mem_words[8'hC1] = 32'h1111_0000;
      mem_words[8'hC2] = 32'h71; mem_words[8'hC3] = 32'h2222_0000;
      mem_words[8'hD0] = 32'h80; mem_words[8'hD1] = 32'hC0DE_0002;
      mem_words[8'hE0] = 32'h90; mem_words[8'hE1] = 32'hC0DE_0005;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset state
      rd(6'd1, s);
      chk(s == 0, "R8 reset status", s, 0);
      chk(irq == 0 && done_flags == 0, "R9 reset irq", {31'd0, irq}, 0);

      // R1 R2: manual pair mode, three entries
      r0 = rd_cnt; w0 = wr_cnt;
      exp_w(32'h60, 32'hFFFF_FFFF); exp_w(32'h61, 32'hFFFF_FFFE); exp_w(32'h62, 32'h1234_5678);
      wr(6'd8, 32'h100); wr(6'd9, 32'h117);
      wr(6'd2, 32'h0); wr(6'd2, 32'h5);
      wait_bits(32'h0100_0000);
      chk(wr_cnt - w0 == 3, "R2 write count", wr_cnt - w0, 3);
      chk(rd_cnt - r0 == 6, "R1 read count", rd_cnt - r0, 6);
      chk(exp_q.size() == 0, "R1 queue drained", exp_q.size(), 0);
      chk(irq == 1, "R9 irq on done", {31'd0, irq}, 1);

      // R8: writing zero keeps flag, writing one clears
      wr(6'd0, 32'h0);
      rd(6'd1, s);
      chk(s[24] == 1, "R8 zero write keeps flag", s, 32'h0100_0000);
      wr(6'd0, 32'h0100_0000);
      rd(6'd1, s);
      chk(s[24] == 0, "R8 w1c clears flag", s, 0);
      chk(irq == 0, "R9 irq low after clear", {31'd0, irq}, 0);

      // R4: start bit already set launches nothing
      w0 = wr_cnt;
      wr(6'd2, 32'h5);
      repeat (40) @(negedge clk);
      rd(6'd1, s);
      chk(s[24] == 0 && wr_cnt == w0, "R4 no relaunch", s, 0);

      // R3: stream mode
      exp_w(32'h3210, 32'hAAAA_0001); exp_w(32'h3211, 32'hAAAA_0002); exp_w(32'h3212, 32'hAAAA_0003);
      w0 = wr_cnt;
      wr(6'd8, 32'h200); wr(6'd9, 32'h20F);
      wr(6'd2, 32'h0); wr(6'd2, 32'h7);
      wait_bits(32'h0100_0000);
      chk(wr_cnt - w0 == 3 && exp_q.size() == 0, "R3 stream writes", wr_cnt - w0, 3);
      wr(6'd0, 32'h0100_0000);

      // R10: window not a multiple of 8
      r0 = rd_cnt; w0 = wr_cnt;
      wr(6'd9, 32'h20B);
      wr(6'd2, 32'h0); wr(6'd2, 32'h5);
      repeat (30) @(negedge clk);
      rd(6'd1, s);
      chk(s[16] == 1 && s[24] == 0, "R10 short window error", s, 32'h0001_0000);
      chk(rd_cnt == r0 && wr_cnt == w0, "R10 short window quiet", rd_cnt - r0, 0);
      wr(6'd0, 32'h0001_0000);
      rd(6'd1, s);
      chk(s[16] == 0, "R10 error clear", s, 0);
      // R10: end before start
      wr(6'd9, 32'h1F7);
      wr(6'd2, 32'h0); wr(6'd2, 32'h5);
      repeat (30) @(negedge clk);
      rd(6'd1, s);
      chk(s[16] == 1 && rd_cnt == r0 && wr_cnt == w0, "R10 reversed window", s, 32'h0001_0000);
      wr(6'd0, 32'h0001_0000);

      // R11: read direction stub
      wr(6'd8, 32'h100); wr(6'd9, 32'h117);
      wr(6'd2, 32'h0); wr(6'd2, 32'h1);
      repeat (20) @(negedge clk);
      rd(6'd1, s);
      chk(s[24] == 1 && rd_cnt == r0 && wr_cnt == w0, "R11 read stub", s, 32'h0100_0000);
      wr(6'd0, 32'h0100_0000);

      // R5: auto channel 1 on trigger 2
      wr(6'd10, 32'h300); wr(6'd11, 32'h30F);
      wr(6'd3, 32'h20);
      wr(6'd24, 32'h2);
      pulse(4'b0100);
      repeat (30) @(negedge clk);
      rd(6'd1, s);
      chk(s[25] == 0 && wr_cnt == w0 && rd_cnt == r0, "R5 disarmed ignored", s, 0);
      wr(6'd24, 32'h22);
      pulse(4'b0010);
      repeat (30) @(negedge clk);
      rd(6'd1, s);
      chk(s[25] == 0 && wr_cnt == w0, "R5 other source ignored", s, 0);
      exp_w(32'h70, 32'h1111_0000); exp_w(32'h71, 32'h2222_0000);
      pulse(4'b0100);
      wait_bits(32'h0200_0000);
      chk(wr_cnt - w0 == 2 && exp_q.size() == 0, "R5 armed run", wr_cnt - w0, 2);
      wr(6'd0, 32'h0200_0000);

      // R6: manual and two auto channels requested together
      w0 = wr_cnt;
      wr(6'd12, 32'h340); wr(6'd13, 32'h347);
      wr(6'd18, 32'h380); wr(6'd19, 32'h387);
      wr(6'd3, 32'h60);
      wr(6'd4, 32'h20);
      wr(6'd25, 32'h20); wr(6'd28, 32'h20);
      wr(6'd2, 32'h0);
      exp_w(32'h60, 32'hFFFF_FFFF); exp_w(32'h61, 32'hFFFF_FFFE); exp_w(32'h62, 32'h1234_5678);
      exp_w(32'h80, 32'hC0DE_0002); exp_w(32'h90, 32'hC0DE_0005);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = 6'd2; csr_wdata = 32'h5; trig_in = 4'b0001;
      @(negedge clk);
      csr_we = 1'b0; csr_addr = 6'd1; trig_in = '0;
      wait_bits(32'h2500_0000);
      rd(6'd1, s);
      chk(s[31:24] == 8'h25, "R6 done set", s, 32'h2500_0000);
      chk(wr_cnt - w0 == 5 && exp_q.size() == 0, "R6 order and hold", wr_cnt - w0, 5);
      chk(irq == 1, "R9 irq with several flags", {31'd0, irq}, 1);
      wr(6'd0, 32'h0400_0000);
      chk(irq == 1, "R9 irq until all cleared", {31'd0, irq}, 1);
      wr(6'd0, 32'hFF00_0000);
      chk(irq == 0 && done_flags == 0, "R9 irq low", {24'd0, done_flags}, 0);

      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule